// File: doc/BRIEF.md
# Serial byte-addressed RAM with SPI slave port

This block is a 2048-byte storage array that answers as a slave on a four-wire SPI bus. A bus master lowers chip select and shifts in a command byte. For data transfers it then sends a two-byte address and streams data bytes in or out. The address advances after every byte, so one command can cover any run of locations. Writes land in the array as each byte completes. No busy state exists, and the next transaction can read the data back at once.

The serial pins are oversampled by a system clock. The chip select, serial clock and serial input each pass through a two-stage synchronizer, and the edges of the serial clock are found in the system clock domain. Input bits are taken on rising serial clock edges. Output bits change on falling edges. Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) work without configuration. A write-enable latch guards the array against stray write commands.

Top module: `spi_fram`

## Requirements
- R1: A synchronous reset drives `so_oe` low and clears the write-enable latch. After reset, a write command with no prior enable command leaves the array unchanged. Reset does not alter array contents.
- R2: While `cs_n` is high, `so_oe` stays low and toggling `sck` and `si` changes no stored byte.
- R3: Opcode 0x03 reads. After the opcode and two address bytes, the byte at that address appears on `so`, most significant bit first. Each bit changes on a falling `sck` edge and is valid at the next rising edge. `so_oe` is low during the opcode and address bytes and high during the data bytes.
- R4: Opcode 0x02 writes when the write-enable latch is set. Each complete data byte is stored at the current address and can be read by the very next transaction.
- R5: Opcode 0x04 clears the write-enable latch, so a following write command stores nothing.
- R6: Opcode 0x06 sets the write-enable latch. The latch clears when chip select rises at the end of a write command, so a second write command without a new 0x06 stores nothing.
- R7: The address is the 16 bits after the opcode, first byte high. Only the low 11 bits select a location and the top 5 bits are ignored.
- R8: In read and write bursts the address increments after each byte and wraps from 0x7FF to 0x000.
- R9: A data byte cut short by chip select rising before its eighth bit is not stored. Bytes completed earlier in the same burst are kept.
- R10: Any opcode other than 0x02, 0x03, 0x04 and 0x06 keeps `so_oe` low, stores nothing and leaves the write-enable latch as it was.
- R11: Reads and writes give the same results in mode 0 (`sck` idle low) and mode 3 (`sck` idle high).
- R12: Only the first byte after chip select falls is decoded as an opcode. In a select period that starts with 0x06, a following 0x04 byte does not clear the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the bus master |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
The assertions take for granted that every level of `sck`, `si` and `cs_n` is held for at least three system clock cycles. Given that, the synchronized edges are seen exactly once and in order, and `si` has settled when a rising edge is detected. The bench holds every serial phase for six system cycles. It changes `si` only together with a falling `sck`, and it changes `cs_n` only while `sck` rests at its idle level. Under these conditions the latch, wrap and output-stability properties can rely on whole bytes framed by chip select.

// File: rtl/spi_fram.sv
module spi_fram #(
  parameter int ADDR_W = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_WREN  = 8'h06;

  logic [2:0] cs_q, sck_q;
  logic [1:0] si_q;
  logic [2:0] bit_cnt;
  logic [6:0] sh;
  logic [1:0] phase;
  logic [7:0] op;
  logic [ADDR_W-1:0] addr;
  logic wel, rd_act, so_r;
  logic [7:0] out_sh;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= '1;
      sck_q <= '0;
      si_q  <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      si_q  <= {si_q[0], si};
    end
  end

  wire cs_act    = ~cs_q[1];
  wire cs_rise   = cs_q[1] & ~cs_q[2];
  wire rise      = cs_act & sck_q[1] & ~sck_q[2];
  wire fall      = cs_act & ~sck_q[1] & sck_q[2];
  wire [7:0] rx  = {sh, si_q[1]};
  wire byte_done = rise & (bit_cnt == 3'd7);
  wire wr_en     = byte_done & (phase == 2'd3) & (op == OP_WRITE) & wel;
  wire rd_load   = byte_done & (op == OP_READ) & phase[1];
  wire [ADDR_W-1:0] addr_lo = {addr[ADDR_W-1:8], rx};
  wire [ADDR_W-1:0] rd_addr = (phase == 2'd2) ? addr_lo : addr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= rx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      sh      <= '0;
      phase   <= '0;
      op      <= '0;
      addr    <= '0;
      wel     <= 1'b0;
      rd_act  <= 1'b0;
      out_sh  <= '0;
      so_r    <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt <= '0;
      phase   <= '0;
      op      <= '0;
      rd_act  <= 1'b0;
      if (cs_rise && op == OP_WRITE) wel <= 1'b0;
    end else begin
      if (rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        sh      <= {sh[5:0], si_q[1]};
      end
      if (byte_done) begin
        if (phase != 2'd3) phase <= phase + 2'd1;
        case (phase)
          2'd0: begin
            op <= rx;
            if (rx == OP_WREN) wel <= 1'b1;
            if (rx == OP_WRDI) wel <= 1'b0;
          end
          2'd1: addr[ADDR_W-1:8] <= rx[HI_W-1:0];
          2'd2: addr <= addr_lo;
          default: ;
        endcase
      end
      if (rd_load) begin
        out_sh <= mem[rd_addr];
        addr   <= rd_addr + 1'b1;
        rd_act <= 1'b1;
      end
      if (wr_en) addr <= addr + 1'b1;
      if (fall && rd_act) begin
        so_r   <= out_sh[7];
        out_sh <= {out_sh[6:0], 1'b0};
      end
    end
  end

  assign so    = so_r;
  assign so_oe = cs_act & rd_act;
endmodule

module spi_fram_chk #(
  parameter int ADDR_W = 11
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic so,
  input logic so_oe,
  input logic cs_rise,
  input logic fall,
  input logic byte_done,
  input logic wr_en,
  input logic wel,
  input logic [1:0] phase,
  input logic [7:0] rx,
  input logic [7:0] op,
  input logic [ADDR_W-1:0] addr
);
  p_hiz_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe);

  p_oe_read_only_r3: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> (op == 8'h03));

  p_so_steady_r3: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(so));

  p_wrdi_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (byte_done && phase == 2'd0 && rx == 8'h04) |=> !wel);

  p_wel_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && op == 8'h02) |=> !wel);

  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == {ADDR_W{1'b1}}) |=> (addr == '0));
endmodule

bind spi_fram spi_fram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/spi_fram_tb.sv
module spi_fram_tb;
  localparam int HP = 6;
  logic clk = 1'b0;
  logic rst = 1'b1, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  logic m3 = 1'b0;
  int checks = 0, errors = 0;
  logic [7:0] exp_mem [2048];
  logic [7:0] d;

  always #5 clk = ~clk;

  spi_fram u_dut (.clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_lo();
    sck = m3; hp(); cs_n = 1'b0; hp();
  endtask

  task automatic cs_hi();
    if (!m3) begin sck = 1'b0; hp(); end
    cs_n = 1'b1; hp(); hp();
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rxd);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = tx[i]; hp();
      rxd[i] = so; sck = 1'b1; hp();
    end
  endtask

  task automatic cmd1(input logic [7:0] opc);
    logic [7:0] t;
    cs_lo(); xb(opc, t); cs_hi();
  endtask

  function automatic logic [7:0] dat(input logic [7:0] base, input int k);
    return base + 8'(k * 13);
  endfunction

  task automatic wr(input logic [15:0] a, input int n, input logic [7:0] base, input bit take);
    logic [7:0] t;
    cs_lo(); xb(8'h02, t); xb(a[15:8], t); xb(a[7:0], t);
    for (int k = 0; k < n; k++) begin
      xb(dat(base, k), t);
      if (take) exp_mem[11'(a[10:0] + 11'(k))] = dat(base, k);
    end
    cs_hi();
  endtask

  task automatic rd_chk(input logic [15:0] a, input int n, input string tag);
    logic [7:0] t;
    cs_lo(); xb(8'h03, t);
    chk({tag, " oe low in header"}, so_oe, 0);
    xb(a[15:8], t); xb(a[7:0], t);
    for (int k = 0; k < n; k++) begin
      xb(8'h00, t);
      chk(tag, t, exp_mem[11'(a[10:0] + 11'(k))]);
    end
    chk({tag, " oe high in data"}, so_oe, 1);
    cs_hi();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] t;
    bit oe_seen;
    repeat (5) @(negedge clk);
    rst = 1'b0; hp();
    chk("R1 so_oe after reset", so_oe, 0);

    cmd1(8'h06); wr(16'h0010, 1, 8'h11, 1); rd_chk(16'h0010, 1, "R4");
    wr(16'h0010, 1, 8'h5A, 0); rd_chk(16'h0010, 1, "R6");
    cmd1(8'h06); cmd1(8'h04); wr(16'h0010, 1, 8'h22, 0); rd_chk(16'h0010, 1, "R5");

    cmd1(8'h06);
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; hp();
    wr(16'h0010, 1, 8'h33, 0); rd_chk(16'h0010, 1, "R1");

    cmd1(8'h06);
    oe_seen = 0;
    for (int b = 0; b < 4; b++) begin
      logic [7:0] v;
      v = (b == 0) ? 8'h02 : (b == 3) ? 8'h44 : 8'h00;
      if (b == 2) v = 8'h10;
      for (int i = 7; i >= 0; i--) begin
        sck = 1'b0; si = v[i]; hp();
        if (so_oe) oe_seen = 1;
        sck = 1'b1; hp();
        if (so_oe) oe_seen = 1;
      end
    end
    sck = 1'b0; hp(); hp();
    chk("R2 so_oe while deselected", oe_seen, 0);
    rd_chk(16'h0010, 1, "R2");

    cmd1(8'h06); wr(16'hF855, 1, 8'hC7, 1);
    rd_chk(16'h0055, 1, "R7"); rd_chk(16'h3855, 1, "R7");

    cmd1(8'h06); wr(16'h07C0, 128, 8'h05, 1);
    rd_chk(16'h07C0, 128, "R8");
    m3 = 1'b1;
    rd_chk(16'h07FE, 4, "R11");
    cmd1(8'h06); wr(16'h0100, 4, 8'hE1, 1); rd_chk(16'h0100, 4, "R11");
    m3 = 1'b0;

    cmd1(8'h06); wr(16'h0020, 2, 8'h90, 1);
    cmd1(8'h06);
    cs_lo(); xb(8'h02, t); xb(8'h00, t); xb(8'h20, t); xb(8'hC3, t);
    for (int i = 7; i >= 3; i--) begin
      sck = 1'b0; si = 1'b1; hp(); sck = 1'b1; hp();
    end
    cs_hi();
    exp_mem[11'h020] = 8'hC3;
    rd_chk(16'h0020, 2, "R9");

    cmd1(8'h06);
    cs_lo(); xb(8'hA5, t); xb(8'h00, t); xb(8'h10, t); xb(8'h77, t);
    chk("R10 so_oe unknown opcode", so_oe, 0);
    cs_hi();
    rd_chk(16'h0010, 1, "R10");
    wr(16'h0030, 1, 8'h3C, 1); rd_chk(16'h0030, 1, "R10");

    cmd1(8'h06);
    cs_lo(); xb(8'h06, t); xb(8'h04, t); cs_hi();
    wr(16'h0040, 1, 8'h4B, 1); rd_chk(16'h0040, 1, "R12");

    for (int a = 0; a < 2048; a += 37) begin
      logic [10:0] aa;
      aa = 11'(a);
      m3 = aa[0];
      cmd1(8'h06);
      wr({5'b0, aa}, 1, aa[7:0] ^ aa[10:3], 1);
      rd_chk({5'b0, aa}, 1, "R4 sweep");
    end
    m3 = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule